// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block produces the raster timing for a parallel RGB panel: a line sync, a frame sync, a data-enable strobe and a pixel clock-enable. It also reports its position in the raster as a pixel index within the line and a line index within the frame. Downstream pixel-fetch logic uses these to request data. Every horizontal and vertical interval comes from configuration inputs. Most lengths are given as "count minus one". The vertical back and front porches are plain line counts and may be zero. The pixel rate comes from the core clock through a divider whose zero setting bypasses division.

The block has two state machines. The horizontal one walks each line through H_SYNC, H_BACK, H_ACT and H_FRONT, in that order. It moves on after `len` pixel-enable strobes, where `len` is the field plus one. After H_FRONT it wraps to H_SYNC and signals the end of the line.

The vertical one has the states V_IDLE, V_SYNC, V_BACK, V_ACT and V_FRONT. Its transitions are:
- V_IDLE goes to V_SYNC when `enable` is high.
- V_SYNC goes to V_BACK after its lines, or straight to V_ACT when the back porch is zero.
- V_BACK goes to V_ACT.
- V_ACT goes to V_FRONT, or ends the frame when the front porch is zero.
- V_FRONT ends the frame.

At the end of a frame the machine returns to V_SYNC if `enable` is high and to V_IDLE otherwise. The configuration is copied into shadow registers in every V_IDLE cycle and at every frame end, so a frame always runs on one consistent set of values.

Top module: `lcd_sync_gen`

## Requirements
- R1: After reset, and in V_IDLE, the outputs are in their idle state: `busy`, `de` and `pix_ce` are 0, `pix_x` and `line_y` are 0, and each sync sits at its inactive level.
- R2: While busy, `pix_ce` is high in every core cycle when `cfg_clk_div` is 0. For a value N > 0 it is high in one cycle out of every 2×(N+1), first in the last cycle of the first period after the frame starts. It is 0 while idle.
- R3: A line lasts (hs+1)+(hb+1)+(ha+1)+(hf+1) pixels, taken from `cfg_hsync_m1`, `cfg_hback_m1`, `cfg_hact_m1` and `cfg_hfront_m1`, in the order sync, back porch, active, front porch. `hsync` is active for the first hs+1 pixels. `pix_x` counts 0 up to length−1, advancing once per `pix_ce`.
- R4: A frame lasts (vs+1)+vb+(va+1)+vf lines, where `cfg_vback` and `cfg_vfront` are plain counts and zero skips the phase. `vsync` is active for the first vs+1 lines. `line_y` advances once at the end of each line's front porch and returns to 0 at the frame end.
- R5: `de` is 1 exactly when the pixel lies in the horizontal active interval and the line lies in the vertical active interval.
- R6: `cfg_inv_line` = 1 makes `hsync` active-low, and `cfg_inv_frame` = 1 does the same for `vsync`. With 0 both are active-high. While idle the sync outputs sit at the inactive level of the current inputs.
- R7: Configuration changes made during a frame have no effect on that frame. They take effect from the next frame start.
- R8: `busy` rises the cycle after `enable` is seen high in V_IDLE. If `enable` is low at the end of a frame, the frame is completed and `busy` then drops to 0 with the counters stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | core clock |
| rst_n | input | 1 | active-low asynchronous reset |
| enable | input | 1 | run request, sampled at frame boundaries |
| cfg_hsync_m1 | input | PW | line sync width minus one |
| cfg_hback_m1 | input | PW | horizontal back porch minus one |
| cfg_hact_m1 | input | HW | active pixels per line minus one |
| cfg_hfront_m1 | input | PW | horizontal front porch minus one |
| cfg_vsync_m1 | input | PW | frame sync width in lines minus one |
| cfg_vback | input | PW | vertical back porch in lines (0 allowed) |
| cfg_vact_m1 | input | VW | active lines minus one |
| cfg_vfront | input | PW | vertical front porch in lines (0 allowed) |
| cfg_clk_div | input | DIVW | pixel divider, 0 = bypass |
| cfg_inv_line | input | 1 | 1 = line sync active-low |
| cfg_inv_frame | input | 1 | 1 = frame sync active-low |
| pix_ce | output | 1 | pixel clock-enable |
| hsync | output | 1 | line sync |
| vsync | output | 1 | frame sync |
| de | output | 1 | data-enable |
| pix_x | output | HW+2 | pixel index within the line |
| line_y | output | VW+2 | line index within the frame |
| busy | output | 1 | a frame is in progress |

## Verification
The bench models every output cycle by cycle from elapsed time and the active configuration. It compares them over whole frames. Directed runs use the all-minimum raster in bypass, inverted polarities with a zero back porch, and a zero front porch with a slow divider. Together these separate the skip paths of the vertical machine and the two divider modes. Seeded random configurations then cover other interval mixes. Each run spans two frames and changes the inputs halfway through the first, so the bench can tell frame-boundary capture apart from live use of the inputs. Dropping `enable` halfway through the last frame shows whether the frame completes before `busy` falls.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

    typedef enum logic [1:0] {
        H_SYNC,
        H_BACK,
        H_ACT,
        H_FRONT
    } h_phase_e;

    typedef enum logic [2:0] {
        V_IDLE,
        V_SYNC,
        V_BACK,
        V_ACT,
        V_FRONT
    } v_state_e;

endpackage

// File: rtl/lcd_pix_divider.sv
module lcd_pix_divider #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            ce
);
    logic [DIVW:0] cnt_q;
    logic [DIVW:0] last;
    logic          bypass;

    assign last   = {div, 1'b1};
    assign bypass = (div == '0);
    assign ce     = run && (bypass || (cnt_q == last));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || bypass || (cnt_q == last)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
    import lcd_sync_pkg::*;
#(
    parameter int PW    = 8,
    parameter int HW    = 11,
    parameter int POS_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ce,
    input  logic [PW-1:0]    sync_m1,
    input  logic [PW-1:0]    back_m1,
    input  logic [HW-1:0]    act_m1,
    input  logic [PW-1:0]    front_m1,
    output h_phase_e         phase,
    output logic [POS_W-1:0] pos,
    output logic             line_end
);
    localparam int SEG_W = (HW > PW) ? HW : PW;

    h_phase_e         state_q, state_d;
    logic [SEG_W-1:0] seg_q;
    logic [SEG_W-1:0] seg_len_m1;
    logic             seg_last;

    always_comb begin
        unique case (state_q)
            H_SYNC:  seg_len_m1 = SEG_W'(sync_m1);
            H_BACK:  seg_len_m1 = SEG_W'(back_m1);
            H_ACT:   seg_len_m1 = SEG_W'(act_m1);
            H_FRONT: seg_len_m1 = SEG_W'(front_m1);
        endcase
    end

    assign seg_last = (seg_q == seg_len_m1);
    assign line_end = ce && (state_q == H_FRONT) && seg_last;
    assign phase    = state_q;

    always_comb begin
        state_d = state_q;
        if (ce && seg_last) begin
            unique case (state_q)
                H_SYNC:  state_d = H_BACK;
                H_BACK:  state_d = H_ACT;
                H_ACT:   state_d = H_FRONT;
                H_FRONT: state_d = H_SYNC;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= H_SYNC;
            seg_q   <= '0;
            pos     <= '0;
        end else if (!run) begin
            state_q <= H_SYNC;
            seg_q   <= '0;
            pos     <= '0;
        end else if (ce) begin
            state_q <= state_d;
            seg_q   <= seg_last ? '0 : seg_q + 1'b1;
            pos     <= line_end ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_sync_pkg::*;
#(
    parameter int PW   = 8,
    parameter int HW   = 11,
    parameter int VW   = 10,
    parameter int DIVW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PW-1:0]     cfg_hsync_m1,
    input  logic [PW-1:0]     cfg_hback_m1,
    input  logic [HW-1:0]     cfg_hact_m1,
    input  logic [PW-1:0]     cfg_hfront_m1,
    input  logic [PW-1:0]     cfg_vsync_m1,
    input  logic [PW-1:0]     cfg_vback,
    input  logic [VW-1:0]     cfg_vact_m1,
    input  logic [PW-1:0]     cfg_vfront,
    input  logic [DIVW-1:0]   cfg_clk_div,
    input  logic              cfg_inv_line,
    input  logic              cfg_inv_frame,
    output logic              pix_ce,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [HW+1:0]     pix_x,
    output logic [VW+1:0]     line_y,
    output logic              busy
);
    localparam int HPOS_W = HW + 2;
    localparam int VPOS_W = VW + 2;
    localparam int VL_W   = ((VW > PW) ? VW : PW) + 1;

    // shadow copy of the configuration, frozen for the whole frame
    logic [PW-1:0]   sh_hsync_m1, sh_hback_m1, sh_hfront_m1;
    logic [HW-1:0]   sh_hact_m1;
    logic [PW-1:0]   sh_vsync_m1, sh_vback, sh_vfront;
    logic [VW-1:0]   sh_vact_m1;
    logic [DIVW-1:0] sh_clk_div;
    logic            sh_inv_line, sh_inv_frame;

    v_state_e         state_q, state_d;
    logic [VL_W-1:0]  v_cnt_q;
    logic [VL_W-1:0]  v_len_m1;
    logic             v_last;
    logic             line_end;
    logic             frame_end;
    logic             shadow_load;
    logic             run;
    h_phase_e         h_phase;

    assign run = (state_q != V_IDLE);

    lcd_pix_divider #(.DIVW(DIVW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .div   (sh_clk_div),
        .ce    (pix_ce)
    );

    lcd_line_timer #(.PW(PW), .HW(HW), .POS_W(HPOS_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .ce       (pix_ce),
        .sync_m1  (sh_hsync_m1),
        .back_m1  (sh_hback_m1),
        .act_m1   (sh_hact_m1),
        .front_m1 (sh_hfront_m1),
        .phase    (h_phase),
        .pos      (pix_x),
        .line_end (line_end)
    );

    // length of the current vertical phase, minus one
    always_comb begin
        unique case (state_q)
            V_SYNC:  v_len_m1 = VL_W'(sh_vsync_m1);
            V_BACK:  v_len_m1 = VL_W'(sh_vback) - 1'b1;
            V_ACT:   v_len_m1 = VL_W'(sh_vact_m1);
            V_FRONT: v_len_m1 = VL_W'(sh_vfront) - 1'b1;
            default: v_len_m1 = '0;
        endcase
    end

    assign v_last    = (v_cnt_q == v_len_m1);
    assign frame_end = line_end && v_last &&
                       (((state_q == V_ACT) && (sh_vfront == '0)) || (state_q == V_FRONT));
    assign shadow_load = (state_q == V_IDLE) || frame_end;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            V_IDLE:  if (enable) state_d = V_SYNC;
            V_SYNC:  if (line_end && v_last)
                         state_d = (sh_vback != '0) ? V_BACK : V_ACT;
            V_BACK:  if (line_end && v_last) state_d = V_ACT;
            V_ACT:   if (line_end && v_last)
                         state_d = (sh_vfront != '0) ? V_FRONT :
                                   (enable ? V_SYNC : V_IDLE);
            V_FRONT: if (line_end && v_last)
                         state_d = enable ? V_SYNC : V_IDLE;
            default: state_d = V_IDLE;
        endcase
    end

    // state register and vertical counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= V_IDLE;
            v_cnt_q <= '0;
            line_y  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == V_IDLE) begin
                v_cnt_q <= '0;
                line_y  <= '0;
            end else if (line_end) begin
                v_cnt_q <= v_last ? '0 : v_cnt_q + 1'b1;
                line_y  <= frame_end ? '0 : line_y + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hsync_m1  <= '0;
            sh_hback_m1  <= '0;
            sh_hact_m1   <= '0;
            sh_hfront_m1 <= '0;
            sh_vsync_m1  <= '0;
            sh_vback     <= '0;
            sh_vact_m1   <= '0;
            sh_vfront    <= '0;
            sh_clk_div   <= '0;
            sh_inv_line  <= 1'b0;
            sh_inv_frame <= 1'b0;
        end else if (shadow_load) begin
            sh_hsync_m1  <= cfg_hsync_m1;
            sh_hback_m1  <= cfg_hback_m1;
            sh_hact_m1   <= cfg_hact_m1;
            sh_hfront_m1 <= cfg_hfront_m1;
            sh_vsync_m1  <= cfg_vsync_m1;
            sh_vback     <= cfg_vback;
            sh_vact_m1   <= cfg_vact_m1;
            sh_vfront    <= cfg_vfront;
            sh_clk_div   <= cfg_clk_div;
            sh_inv_line  <= cfg_inv_line;
            sh_inv_frame <= cfg_inv_frame;
        end
    end

    // output decode
    always_comb begin
        busy  = run;
        hsync = (run && (h_phase == H_SYNC)) ^ sh_inv_line;
        vsync = (state_q == V_SYNC) ^ sh_inv_frame;
        de    = (state_q == V_ACT) && (h_phase == H_ACT);
    end
endmodule

// File: rtl/lcd_sync_checker.sv
module lcd_sync_checker #(
    parameter int HPOS_W = 13,
    parameter int VPOS_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              busy,
    input logic              pix_ce,
    input logic              de,
    input logic              hsync,
    input logic              vsync,
    input logic [HPOS_W-1:0] pix_x,
    input logic [VPOS_W-1:0] line_y,
    input logic              sh_inv_line,
    input logic              sh_inv_frame
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!de && !pix_ce && (pix_x == '0) && (line_y == '0))); // R1

    AST_X_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pix_ce) |=> $stable(pix_x)); // R3

    AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pix_ce) |=> ((pix_x == $past(pix_x) + 1'b1) || (pix_x == '0))); // R3

    AST_Y_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pix_ce) |=> $stable(line_y)); // R4

    AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((hsync == sh_inv_line) && (vsync == sh_inv_frame))); // R5

    AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(pix_ce) && !$past(enable))); // R8
endmodule

bind lcd_sync_gen lcd_sync_checker #(.HPOS_W(HPOS_W), .VPOS_W(VPOS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .busy         (busy),
    .pix_ce       (pix_ce),
    .de           (de),
    .hsync        (hsync),
    .vsync        (vsync),
    .pix_x        (pix_x),
    .line_y       (line_y),
    .sh_inv_line  (sh_inv_line),
    .sh_inv_frame (sh_inv_frame)
);

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8, HW = 11, VW = 10, DIVW = 8;

    typedef struct {
        int hs, hb, ha, hf, vs, vb, va, vf, dv, il, ifr;
    } cfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [PW-1:0] cfg_hsync_m1 = '0, cfg_hback_m1 = '0, cfg_hfront_m1 = '0;
    logic [HW-1:0] cfg_hact_m1 = '0;
    logic [PW-1:0] cfg_vsync_m1 = '0, cfg_vback = '0, cfg_vfront = '0;
    logic [VW-1:0] cfg_vact_m1 = '0;
    logic [DIVW-1:0] cfg_clk_div = '0;
    logic cfg_inv_line = 1'b0, cfg_inv_frame = 1'b0;
    logic pix_ce, hsync, vsync, de, busy;
    logic [HW+1:0] pix_x;
    logic [VW+1:0] line_y;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_sync_gen #(.PW(PW), .HW(HW), .VW(VW), .DIVW(DIVW)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_hsync_m1(cfg_hsync_m1), .cfg_hback_m1(cfg_hback_m1),
        .cfg_hact_m1(cfg_hact_m1), .cfg_hfront_m1(cfg_hfront_m1),
        .cfg_vsync_m1(cfg_vsync_m1), .cfg_vback(cfg_vback),
        .cfg_vact_m1(cfg_vact_m1), .cfg_vfront(cfg_vfront),
        .cfg_clk_div(cfg_clk_div), .cfg_inv_line(cfg_inv_line),
        .cfg_inv_frame(cfg_inv_frame),
        .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
        .pix_x(pix_x), .line_y(line_y), .busy(busy)
    );

    function automatic int period(cfg_t c);
        return (c.dv == 0) ? 1 : 2 * (c.dv + 1);
    endfunction

    function automatic int htot(cfg_t c);
        return c.hs + c.hb + c.ha + c.hf + 4;
    endfunction

    function automatic int vtot(cfg_t c);
        return c.vs + 1 + c.vb + c.va + 1 + c.vf;
    endfunction

    function automatic int frame_cycles(cfg_t c);
        return htot(c) * vtot(c) * period(c);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic apply(cfg_t c);
        cfg_hsync_m1  = PW'(c.hs);
        cfg_hback_m1  = PW'(c.hb);
        cfg_hact_m1   = HW'(c.ha);
        cfg_hfront_m1 = PW'(c.hf);
        cfg_vsync_m1  = PW'(c.vs);
        cfg_vback     = PW'(c.vb);
        cfg_vact_m1   = VW'(c.va);
        cfg_vfront    = PW'(c.vf);
        cfg_clk_div   = DIVW'(c.dv);
        cfg_inv_line  = c.il[0];
        cfg_inv_frame = c.ifr[0];
    endtask

    // compare every output against the timing model at cycle t of a frame
    task automatic check_cycle(cfg_t c, int t, bit later);
        int p, x, y, h0, v0;
        string pre;
        pre = later ? "R7 " : "";
        p  = t / period(c);
        x  = p % htot(c);
        y  = p / htot(c);
        h0 = c.hs + c.hb + 2;
        v0 = c.vs + 1 + c.vb;
        check({pre, "R2"}, "pix_ce", int'(pix_ce), int'((t % period(c)) == period(c) - 1));
        check({pre, "R3 R6"}, "hsync", int'(hsync), int'(x <= c.hs) ^ c.il);
        check({pre, "R4 R6"}, "vsync", int'(vsync), int'(y <= c.vs) ^ c.ifr);
        check({pre, "R5"}, "de", int'(de),
              int'((x >= h0) && (x < h0 + c.ha + 1) && (y >= v0) && (y < v0 + c.va + 1)));
        check({pre, "R3"}, "pix_x", int'(pix_x), x);
        check({pre, "R4"}, "line_y", int'(line_y), y);
        check({pre, "R8"}, "busy", int'(busy), 1);
    endtask

    task automatic check_idle(cfg_t c, string req);
        check(req, "busy", int'(busy), 0);
        check(req, "de", int'(de), 0);
        check(req, "pix_ce", int'(pix_ce), 0);
        check(req, "pix_x", int'(pix_x), 0);
        check(req, "line_y", int'(line_y), 0);
        check({req, " R6"}, "hsync idle", int'(hsync), c.il);
        check({req, " R6"}, "vsync idle", int'(vsync), c.ifr);
    endtask

    // a: first frame, b: applied mid first frame for the second, n: noise applied mid last frame
    task automatic run_frames(cfg_t a, cfg_t b, cfg_t n, int nf);
        apply(a);
        enable = 1'b1;
        @(posedge clk);
        for (int f = 0; f < nf; f++) begin
            cfg_t cur;
            int fc;
            cur = (f == 0) ? a : b;
            fc  = frame_cycles(cur);
            for (int t = 0; t < fc; t++) begin
                @(negedge clk);
                check_cycle(cur, t, f > 0);
                if (t == fc / 2) begin
                    if (f < nf - 1) begin
                        apply(b);
                    end else begin
                        apply(n);
                        enable = 1'b0;
                    end
                end
            end
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check_idle(n, "R8");
        end
    endtask

    function automatic cfg_t rnd_cfg();
        cfg_t c;
        c.hs = $urandom_range(0, 3);
        c.hb = $urandom_range(0, 3);
        c.ha = $urandom_range(0, 15);
        c.hf = $urandom_range(0, 3);
        c.vs = $urandom_range(0, 2);
        c.vb = $urandom_range(0, 2);
        c.va = $urandom_range(0, 7);
        c.vf = $urandom_range(0, 2);
        c.dv = $urandom_range(0, 3);
        c.il = $urandom_range(0, 1);
        c.ifr = $urandom_range(0, 1);
        return c;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : stim
        cfg_t zero, d1, d2, d3, a, b, n;
        void'($urandom(32'd20240611));
        zero = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle(zero, "R1");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_idle(zero, "R1");

        // R6: idle sync levels follow polarity inputs
        d1 = zero; d1.il = 1; d1.ifr = 1;
        apply(d1);
        repeat (2) @(negedge clk);
        check_idle(d1, "R6");

        // minimum raster in bypass, then inverted polarities with zero back porch
        d1 = zero;
        d2 = '{1, 0, 5, 2, 1, 0, 3, 3, 2, 1, 1};
        run_frames(d1, d2, zero, 2);

        // slow divider, zero front porch, then bypass with both porches zero
        d3 = '{2, 1, 3, 0, 0, 2, 2, 0, 5, 0, 1};
        d1 = '{0, 2, 7, 1, 1, 0, 4, 0, 0, 1, 0};
        run_frames(d3, d1, d2, 2);

        // single frame: enable dropped mid frame
        run_frames(d2, d2, d3, 1);

        for (int i = 0; i < 10; i++) begin
            a = rnd_cfg();
            b = rnd_cfg();
            n = rnd_cfg();
            run_frames(a, b, n, 2);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule